// File: doc/BRIEF.md
# System Tick Timer

A periodic down-counter for generating an operating-system time base. Software programs a reload value, chooses whether the counter advances on every core clock cycle or only on cycles where a slower reference strobe is high, and enables it. Each time the count is exhausted, the timer raises a sticky count-reached flag. If interrupt generation is enabled, it also sends a single-cycle request pulse to an interrupt controller.

Access is through a plain word port. Read data follows the address combinationally. A read has side effects only when the read strobe is high, and a write has side effects only when the write strobe is high. The four registers are control/status (0x10), reload (0x14), current count (0x18) and a read-only calibration word (0x1C). Three side effects matter to software. Reading control clears the flag. Writing the current-count register restarts the period. A reload value of zero turns the timer into a one-shot that switches itself off.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, control, reload and current count read zero, calibration reads 10000 and `irq_o` is low.
- R2: The control register holds enable at bit 0, interrupt-enable at bit 1, clock-source at bit 2 and the count-reached flag at bit 16. A write changes only bits 2:0, and all other bits read zero.
- R3: The reload register stores the low CNT_W bits of the written word and reads back zero-extended.
- R4: While enabled, one period lasts reload+1 ticks. After a write to the current-count register, the first expiry comes reload+1 ticks after the write. Enabling from the reset state loads the reload value first.
- R5: When clock-source is 1, the counter ticks on every cycle. When it is 0, the counter ticks only on cycles where `ref_tick_i` is high.
- R6: Expiry sets the flag. A control read with `re_i` high clears it, unless an expiry happens in the same cycle. Looking at the control register with `re_i` low leaves the flag alone.
- R7: `irq_o` pulses for one cycle after an expiry, and only when interrupt-enable is 1. With interrupt-enable 0, the flag is still set.
- R8: If the reload value is zero at expiry, the enable bit clears itself and no further expiry follows.
- R9: Any write to the current-count register reloads the count from the reload register and clears the flag. The written data has no effect.
- R10: The current-count register reads zero while enable is 0.
- R11: The calibration register reads 10000. Writes to it change nothing. Unmapped addresses read zero.
- R12: Clearing enable freezes the count. Setting enable again resumes from the frozen value instead of reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference strobe, one cycle per reference tick |
| re_i | input | 1 | Read strobe; enables read side effects |
| we_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench sweeps several reload values on the core clock and on two reference-strobe ratios, and measures the cycle distance between request pulses. A counter that is off by one in its period, or that ignores the strobe, produces the wrong gaps. It suspends and resumes a long count and times the next pulse. A design that reloads on re-enable would fire a full period late. It also checks the one-shot case with a zero reload: a design that keeps running would pulse again. It exercises the flag's clear paths: an ordinary look, a read, and a current-count write with arbitrary data, which must restart the period from the reload value rather than from the written word.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;
  localparam int OFF_CTRL = 'h10;
  localparam int OFF_LOAD = 'h14;
  localparam int OFF_CUR  = 'h18;
  localparam int OFF_CAL  = 'h1C;

  localparam int CB_EN   = 0;
  localparam int CB_IE   = 1;
  localparam int CB_SRC  = 2;
  localparam int CB_FLAG = 16;

  localparam logic [31:0] CAL_WORD = 32'd10000;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/stk_tick_sel.sv
module stk_tick_sel (
  input  logic en_i,
  input  logic src_i,
  input  logic ref_tick_i,
  output logic tick_o
);
  // src 1: core clock, src 0: reference strobe
  assign tick_o = en_i & (src_i | ref_tick_i);
endmodule

// File: rtl/stk_counter.sv
module stk_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cur_q;
  logic             fresh_q;
  logic             at_zero;

  assign at_zero  = (cur_q == '0);
  assign expire_o = tick_i & ~load_i & at_zero;
  assign stop_o   = expire_o & (reload_i == '0);
  assign cur_o    = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      fresh_q <= 1'b1;
    end else if (load_i) begin
      cur_q   <= reload_i;
      fresh_q <= 1'b0;
    end else if (start_i && fresh_q) begin
      cur_q   <= reload_i;
      fresh_q <= 1'b0;
    end else if (tick_i) begin
      if (at_zero) begin
        if (reload_i == '0) fresh_q <= 1'b1;
        else                cur_q   <= reload_i;
      end else begin
        cur_q <= cur_q - CNT_W'(1);
      end
    end
  end

  // R12
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !start_i) |=> $stable(cur_o));

  // R4
  reload_on_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !stop_o) |=> (cur_o == $past(reload_i)));

  // R9
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cur_o == $past(reload_i)));
endmodule

// File: rtl/stk_ctrl_regs.sv
module stk_ctrl_regs
  import sys_tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ctrl_re_i,
  input  logic             load_we_i,
  input  logic             cur_we_i,
  input  logic [2:0]       ctrl_wdata_i,
  input  logic [CNT_W-1:0] load_wdata_i,
  input  logic             expire_i,
  input  logic             stop_i,
  output ctrl_t            ctrl_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             start_o
);
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic [CNT_W-1:0] reload_q;

  assign start_o  = ctrl_we_i & ctrl_wdata_i[CB_EN] & ~ctrl_q.en;
  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign reload_o = reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q.en  <= ctrl_wdata_i[CB_EN];
      ctrl_q.ie  <= ctrl_wdata_i[CB_IE];
      ctrl_q.src <= ctrl_wdata_i[CB_SRC];
    end else if (stop_i) begin
      ctrl_q.en <= 1'b0;
    end
  end

  // a new expiry outranks any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_q <= 1'b0;
    else if (expire_i)                flag_q <= 1'b1;
    else if (ctrl_re_i || cur_we_i)   flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reload_q <= '0;
    else if (load_we_i) reload_q <= load_wdata_i;
  end

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_o);

  // R6
  flag_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_re_i && !expire_i) |=> !flag_o);

  // R9
  flag_cur_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_we_i |=> !flag_o);
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import sys_tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic             sel_ctrl, sel_load, sel_cur, sel_cal;
  logic             tick, start, expire, stop, flag;
  logic [CNT_W-1:0] reload, cur;
  logic [31:0]      reload_w, cur_w, ctrl_w;
  ctrl_t            ctrl;
  logic             irq_q;

  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_load = (addr_i == ADDR_W'(OFF_LOAD));
  assign sel_cur  = (addr_i == ADDR_W'(OFF_CUR));
  assign sel_cal  = (addr_i == ADDR_W'(OFF_CAL));

  stk_ctrl_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (we_i & sel_ctrl),
    .ctrl_re_i    (re_i & sel_ctrl),
    .load_we_i    (we_i & sel_load),
    .cur_we_i     (we_i & sel_cur),
    .ctrl_wdata_i (wdata_i[2:0]),
    .load_wdata_i (wdata_i[CNT_W-1:0]),
    .expire_i     (expire),
    .stop_i       (stop),
    .ctrl_o       (ctrl),
    .flag_o       (flag),
    .reload_o     (reload),
    .start_o      (start)
  );

  stk_tick_sel i_sel (
    .en_i       (ctrl.en),
    .src_i      (ctrl.src),
    .ref_tick_i (ref_tick_i),
    .tick_o     (tick)
  );

  stk_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .start_i  (start),
    .load_i   (we_i & sel_cur),
    .reload_i (reload),
    .cur_o    (cur),
    .expire_o (expire),
    .stop_o   (stop)
  );

  generate
    if (CNT_W < 32) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata_i[31:CNT_W];
      assign reload_w  = {{(32-CNT_W){1'b0}}, reload};
      assign cur_w     = {{(32-CNT_W){1'b0}}, cur};
    end else begin : g_full
      assign reload_w = reload;
      assign cur_w    = cur;
    end
  endgenerate

  always_comb begin
    ctrl_w          = '0;
    ctrl_w[CB_EN]   = ctrl.en;
    ctrl_w[CB_IE]   = ctrl.ie;
    ctrl_w[CB_SRC]  = ctrl.src;
    ctrl_w[CB_FLAG] = flag;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o = ctrl_w;
    else if (sel_load) rdata_o = reload_w;
    else if (sel_cur)  rdata_o = ctrl.en ? cur_w : '0;
    else if (sel_cal)  rdata_o = CAL_WORD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= expire & ctrl.ie;
  end
  assign irq_o = irq_q;

  // R7
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);

  // R8
  auto_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !(we_i && sel_ctrl)) |=> !ctrl.en);

  // R5
  ref_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.src && !ref_tick_i) |-> !expire);
endmodule

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0;
  logic        re_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  logic done = 1'b0;

  sys_tick_timer #(.CNT_W(24), .ADDR_W(8)) i_sys_tick_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .re_i(re_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1; ref_tick_i = 1'b0;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr_i = a; re_i = 1'b1;
    #1;
    v = rdata_o;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  // cycles until irq_o seen; div 0 = no reference strobes; -1 on timeout
  task automatic wait_irq(input int div, input int maxc, output int k);
    k = -1;
    for (int i = 1; i <= maxc; i++) begin
      if (div == 0) ref_tick_i = 1'b0;
      else begin
        ref_tick_i = (ph == div - 1);
        ph = (ph == div - 1) ? 0 : ph + 1;
      end
      @(negedge clk_i);
      if (irq_o) begin k = i; break; end
    end
    ref_tick_i = 1'b0;
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (irq_o) c++;
    end
  endtask

  task automatic restart(input int r, input logic [31:0] c);
    wr(8'h10, 32'h0);
    wr(8'h14, r);
    wr(8'h18, 32'h0);
    wr(8'h10, c);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k, k2, c, v0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    peek(8'h10, v); chk(v == 0, "R1 ctrl", v, 0);
    peek(8'h14, v); chk(v == 0, "R1 reload", v, 0);
    peek(8'h18, v); chk(v == 0, "R1 current", v, 0);
    peek(8'h1C, v); chk(v == 10000, "R1 calib", v, 10000);
    chk(irq_o == 0, "R1 irq", irq_o, 0);

    // R2 only bits 2:0 writable
    wr(8'h10, 32'hFFFF_FFF8);
    peek(8'h10, v); chk(v == 0, "R2 upper bits", v, 0);
    wr(8'h10, 32'h0001_0006);
    peek(8'h10, v); chk(v == 6, "R2 ie+src", v, 6);

    // R3 reload width
    wr(8'h14, 32'hFFFF_FFFF);
    peek(8'h14, v); chk(v == 32'h00FF_FFFF, "R3 reload mask", v, 32'h00FF_FFFF);

    // R10 current zero while disabled, even after a load
    wr(8'h18, 32'h0);
    peek(8'h18, v); chk(v == 0, "R10 disabled read", v, 0);

    // R11 calibration write ignored, unmapped read zero
    wr(8'h1C, 32'h0);
    peek(8'h1C, v); chk(v == 10000, "R11 calib after write", v, 10000);
    peek(8'h10, v); chk(v == 6, "R11 ctrl unchanged", v, 6);
    peek(8'h20, v); chk(v == 0, "R11 unmapped", v, 0);

    // R4 R5 core clock sweep: first expiry and steady period
    for (int r = 1; r <= 6; r++) begin
      restart(r, 32'h7);
      wait_irq(0, 100, k);
      wait_irq(0, 100, k2);
      chk(k == r + 1, "R4 first period core", k, r + 1);
      chk(k2 == r + 1, "R5 period core", k2, r + 1);
    end

    // R5 reference strobe sweep
    for (int d = 2; d <= 3; d++) begin
      for (int r = 1; r <= 3; r++) begin
        restart(r, 32'h3);
        ph = 0;
        wait_irq(d, 200, k);
        wait_irq(d, 200, k2);
        chk(k2 == (r + 1) * d, "R5 period ref", k2, (r + 1) * d);
      end
    end

    // R7 no irq with ie=0, flag still set; R6 look vs read
    restart(20, 32'h5);
    count_irq(25, c);
    chk(c == 0, "R7 no irq when ie=0", c, 0);
    peek(8'h10, v); chk(v == 32'h0001_0005, "R6 flag set", v, 32'h0001_0005);
    peek(8'h10, v); chk(v == 32'h0001_0005, "R6 look keeps flag", v, 32'h0001_0005);
    rd(8'h10, v); chk(v == 32'h0001_0005, "R6 read returns flag", v, 32'h0001_0005);
    peek(8'h10, v); chk(v == 32'h0000_0005, "R6 read clears flag", v, 5);

    // R9 current write: reload, clear flag, data ignored
    restart(3, 32'h7);
    wait_irq(0, 50, k);
    peek(8'h10, v); chk(v[16] == 1, "R9 flag before", v[16], 1);
    wr(8'h18, 32'h55);
    peek(8'h10, v); chk(v[16] == 0, "R9 flag cleared", v[16], 0);
    peek(8'h18, v); chk(v == 3, "R9 data ignored", v, 3);
    wait_irq(0, 50, k);
    chk(k == 4, "R9 period restarts", k, 4);

    // R12 freeze and resume
    restart(100, 32'h7);
    repeat (10) @(negedge clk_i);
    peek(8'h18, v); v0 = int'(v);
    wr(8'h10, 32'h6);
    peek(8'h18, v); chk(v == 0, "R10 frozen reads zero", v, 0);
    repeat (5) @(negedge clk_i);
    wr(8'h10, 32'h7);
    peek(8'h18, v); chk(int'(v) == v0 - 1, "R12 resumed value", v, v0 - 1);
    wait_irq(0, 200, k);
    chk(k == v0, "R12 resume timing", k, v0);

    // R8 zero reload one-shot
    restart(0, 32'h7);
    wait_irq(0, 20, k);
    chk(k == 1, "R8 single expiry", k, 1);
    peek(8'h10, v); chk(v == 32'h0001_0006, "R8 enable cleared", v, 32'h0001_0006);
    count_irq(20, c);
    chk(c == 0, "R8 no further irq", c, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule